// File: doc/BRIEF.md
# Half-Rate Dual-Port Sample Demultiplexer with Phase-Realigning Resync

The block takes one 8-bit sample per input clock and spreads the stream over two 8-bit output ports. It also produces a data-ready clock that runs at half rate. Both ports load together on the cycle where the data-ready clock goes high. Each pair puts the older sample on the auxiliary port and the newer one on the primary port. At power-up the phase of the data-ready clock is arbitrary. A parameter models this.

A resync input is sampled on the input clock. The block delays it through its own pipeline and drives it out on a resync output, with the width of the input pulse kept. The resync output is one cycle ahead of the primary data, so its falling edge marks where aligned data starts. Downstream demultiplexers can use it as their own reset. On that falling edge the data-ready clock is forced to a fixed phase. If the clock was already in that phase, nothing is disturbed. If it was not, the clock holds its level for one extra input cycle. After that, the mapping of samples to ports is the opposite of what it was before.

Top module: `dual_port_demux`

## Requirements
- R1: While `rst_ni` is low, both data ports read 0, `resync_o` reads 0 and `drdy_o` equals the power-up phase parameter (0 for `PH_LOW`, 1 for `PH_HIGH`).
- R2: `drdy_o` inverts on every input clock edge except the release edge defined in R7.
- R3: The two data ports change only on an edge where `drdy_o` goes from 0 to 1. On every other edge both ports hold their value.
- R4: On an edge where `drdy_o` rises, `pri_o` takes the sample presented PRI_LAT edges earlier (7 by default) and `aux_o` takes the sample presented PRI_LAT+1 edges earlier. The auxiliary port therefore always holds the older sample of the pair.
- R5: `resync_o` equals `resync_i` as sampled PRI_LAT-1 edges earlier (6 by default). A pulse of any width, including one or two cycles, comes out with the same width.
- R6: While `resync_o` stays high across consecutive cycles, `drdy_o` keeps toggling every cycle.
- R7: The release edge is the edge where `resync_o` goes from 1 to 0. On it `drdy_o` becomes 0. If `drdy_o` was already 1, the clock keeps toggling with no break. If it was 0, it stays low for one extra cycle, swallowing one input cycle, and the ports do not load on that edge.
- R8: From one edge after a release onward, all outputs are the same whichever power-up phase was chosen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Full-rate input clock; all state changes on its rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset; loads the power-up state |
| smp_i | input | SMP_W (8) | Full-rate sample stream, one sample per clock |
| resync_i | input | 1 | Resync request, active high, sampled every clock |
| pri_o | output | SMP_W (8) | Primary port: newer sample of each pair |
| aux_o | output | SMP_W (8) | Auxiliary port: older sample of each pair |
| drdy_o | output | 1 | Half-rate data-ready clock; ports load when it rises |
| resync_o | output | 1 | Delayed resync; its falling edge marks aligned data |

## Verification
Two instances with opposite power-up phases run side by side on the same stimulus. Each test applies a resync pulse with a chosen start cycle and width over one of three data patterns, and each pattern exposes a different fault:
- An ascending ramp shows which port got the older sample and by how many cycles.
- Alternating 0x55/0xAA shows a swap of sample parity between the ports.
- A scrambled sequence catches an off-by-one latency that a periodic pattern would hide.

Pulse starts on both parities and widths of one, two, three and five cycles make sure that in each test exactly one instance swallows a cycle, and that both streams agree after release. A final case issues a second pulse once the clock is already aligned. It confirms that neither instance's clock or data is interrupted by that pulse.

// File: rtl/dpd_pkg.sv
package dpd_pkg;

   // Level of the data-ready clock right after power-up.
   typedef enum logic {
      PH_LOW  = 1'b0,
      PH_HIGH = 1'b1
   } drdy_ph_e;

   localparam int unsigned SMP_W_DEF   = 8;
   localparam int unsigned PRI_LAT_DEF = 7;

endpackage

// File: rtl/dpd_delay_line.sv
// Shift register of DEPTH stages that exposes its last two stages.
module dpd_delay_line #(
   parameter int unsigned W     = 1,
   parameter int unsigned DEPTH = 2
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] last_o,
   output logic [W-1:0] prev_o
);

   if (DEPTH < 2) begin : g_depth_chk
      $error("dpd_delay_line: DEPTH must be at least 2");
   end
   if (W < 1) begin : g_width_chk
      $error("dpd_delay_line: W must be at least 1");
   end

   logic [DEPTH-1:0][W-1:0] stg_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         stg_q <= '0;
      end else begin
         stg_q[0] <= d_i;
         for (int k = 1; k < DEPTH; k++) begin
            stg_q[k] <= stg_q[k-1];
         end
      end
   end

   assign last_o = stg_q[DEPTH-1];
   assign prev_o = stg_q[DEPTH-2];

endmodule

// File: rtl/dpd_phase_gen.sv
// Half-rate data-ready clock, forced low on a resync release edge.
module dpd_phase_gen #(
   parameter dpd_pkg::drdy_ph_e PWRUP_PHASE = dpd_pkg::PH_LOW
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic rel_i,
   output logic drdy_o,
   output logic rise_o
);

   logic drdy_q;
   logic live_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         drdy_q <= PWRUP_PHASE;
         live_q <= 1'b0;
      end else begin
         drdy_q <= rel_i ? 1'b0 : ~drdy_q;
         live_q <= 1'b1;
      end
   end

   assign drdy_o = drdy_q;
   // Ports load only where the clock really goes high; a swallowed cycle keeps it low.
   assign rise_o = ~drdy_q & ~rel_i;

   AST_DRDY_TOGGLE: assert property (@(posedge clk_i) disable iff (!rst_ni) live_q && !rel_i |=> drdy_o != $past(drdy_o)); // R2
   AST_REL_FORCE: assert property (@(posedge clk_i) disable iff (!rst_ni) live_q && rel_i |=> !drdy_o); // R7

endmodule

// File: rtl/dpd_port_pair.sv
// Primary and auxiliary output registers loaded together.
module dpd_port_pair #(
   parameter int unsigned W = 8
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         upd_i,
   input  logic         drdy_i,
   input  logic [W-1:0] new_i,
   input  logic [W-1:0] old_i,
   output logic [W-1:0] pri_o,
   output logic [W-1:0] aux_o
);

   logic [W-1:0] pri_q;
   logic [W-1:0] aux_q;
   logic         live_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         pri_q  <= '0;
         aux_q  <= '0;
         live_q <= 1'b0;
      end else begin
         live_q <= 1'b1;
         if (upd_i) begin
            pri_q <= new_i;
            aux_q <= old_i;
         end
      end
   end

   assign pri_o = pri_q;
   assign aux_o = aux_q;

   AST_PORT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni) live_q && drdy_i |=> $stable(pri_o) && $stable(aux_o)); // R3

endmodule

// File: rtl/dual_port_demux.sv
module dual_port_demux #(
   parameter int unsigned       SMP_W       = dpd_pkg::SMP_W_DEF,
   parameter int unsigned       PRI_LAT     = dpd_pkg::PRI_LAT_DEF,
   parameter dpd_pkg::drdy_ph_e PWRUP_PHASE = dpd_pkg::PH_LOW
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [SMP_W-1:0] smp_i,
   input  logic             resync_i,
   output logic [SMP_W-1:0] pri_o,
   output logic [SMP_W-1:0] aux_o,
   output logic             drdy_o,
   output logic             resync_o
);

   localparam int unsigned AUX_LAT = PRI_LAT + 1;
   localparam int unsigned RSO_LAT = PRI_LAT - 1;

   if (PRI_LAT < 2) begin : g_lat_chk
      $error("dual_port_demux: PRI_LAT must be at least 2");
   end
   if (SMP_W < 1) begin : g_w_chk
      $error("dual_port_demux: SMP_W must be at least 1");
   end

   logic [SMP_W-1:0] smp_old;
   logic [SMP_W-1:0] smp_new;
   logic             rs_last;
   logic             rs_prev;
   logic             rel;
   logic             rise;
   logic             live_q;

   // Sample pipeline: the last stage feeds aux, the one before feeds pri.
   dpd_delay_line #(.W(SMP_W), .DEPTH(AUX_LAT)) u_smp_dl (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (smp_i),
      .last_o (smp_old),
      .prev_o (smp_new)
   );

   // Resync pipeline: one stage shorter than the primary data path.
   dpd_delay_line #(.W(1), .DEPTH(RSO_LAT + 1)) u_rs_dl (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (resync_i),
      .last_o (rs_last),
      .prev_o (rs_prev)
   );

   // Release edge: the output stage is high and the stage behind it is low.
   assign rel = rs_last & ~rs_prev;

   dpd_phase_gen #(.PWRUP_PHASE(PWRUP_PHASE)) u_phase (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .rel_i  (rel),
      .drdy_o (drdy_o),
      .rise_o (rise)
   );

   dpd_port_pair #(.W(SMP_W)) u_ports (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .upd_i  (rise),
      .drdy_i (drdy_o),
      .new_i  (smp_new),
      .old_i  (smp_old),
      .pri_o  (pri_o),
      .aux_o  (aux_o)
   );

   assign resync_o = rs_last;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) live_q <= 1'b0;
      else         live_q <= 1'b1;
   end

   AST_RUN_IN_RESYNC: assert property (@(posedge clk_i) disable iff (!rst_ni) live_q && resync_o && resync_i |=> resync_o |-> drdy_o != $past(drdy_o)); // R6
   AST_RELEASE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni) live_q && $fell(resync_o) |-> !drdy_o); // R7

endmodule

// File: tb/sim_dual_port_demux.sv
module sim_dual_port_demux;

   localparam int P  = 7;
   localparam int R  = P - 1;
   localparam int HN = 512;
   localparam int NV = 6;
   // Each vector: resync start edge, pulse width, data pattern.
   localparam int VEC [NV][3] = '{
      '{20, 2, 0}, '{21, 2, 0}, '{30, 1, 1},
      '{33, 3, 2}, '{40, 5, 0}, '{25, 2, 2}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] smp = '0;
   logic       rsync = 1'b0;
   logic [7:0] pri0, aux0, pri1, aux1;
   logic       drdy0, drdy1, rso0, rso1;

   always #2.5 clk = ~clk;

   dual_port_demux #(.PWRUP_PHASE(dpd_pkg::PH_LOW)) u0 (
      .clk_i(clk), .rst_ni(rst_n), .smp_i(smp), .resync_i(rsync),
      .pri_o(pri0), .aux_o(aux0), .drdy_o(drdy0), .resync_o(rso0));

   dual_port_demux #(.PWRUP_PHASE(dpd_pkg::PH_HIGH)) u1 (
      .clk_i(clk), .rst_ni(rst_n), .smp_i(smp), .resync_i(rsync),
      .pri_o(pri1), .aux_o(aux1), .drdy_o(drdy1), .resync_o(rso1));

   int nchk = 0;
   int nfail = 0;
   bit done = 1'b0;

   int hist_d [HN];
   int hist_r [HN];
   int n;
   int m_drdy [2];
   int m_pri [2];
   int m_aux [2];
   int m_rso;
   int p_drdy [2];
   int p_pri [2];
   int p_aux [2];
   int p_rso;
   int swl [2];
   bit rel_seen;
   int rel_edge;

   task automatic check(input string tag, input int act, input int exp);
      nchk++;
      if (act != exp) begin
         nfail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int getd(input int k);
      return (k < 0) ? 0 : hist_d[k];
   endfunction

   function automatic int getr(input int k);
      return (k < 0) ? 0 : hist_r[k];
   endfunction

   function automatic logic [7:0] pat(input int mode, input int k);
      if (mode == 0)      return 8'(k + 1);
      else if (mode == 1) return k[0] ? 8'hAA : 8'h55;
      else                return 8'(k * 37 + 11);
   endfunction

   function automatic int o_pri(input int i);  return (i == 0) ? int'(pri0)  : int'(pri1);  endfunction
   function automatic int o_aux(input int i);  return (i == 0) ? int'(aux0)  : int'(aux1);  endfunction
   function automatic int o_drdy(input int i); return (i == 0) ? int'(drdy0) : int'(drdy1); endfunction
   function automatic int o_rso(input int i);  return (i == 0) ? int'(rso0)  : int'(rso1);  endfunction

   // System reset, then check the power-up state (R1) and clear the model.
   task automatic sys_reset();
      rst_n = 1'b0;
      rsync = 1'b0;
      smp = '0;
      repeat (3) @(negedge clk);
      for (int i = 0; i < 2; i++) begin
         check("R1 primary in reset", o_pri(i), 0);
         check("R1 auxiliary in reset", o_aux(i), 0);
         check("R1 resync out in reset", o_rso(i), 0);
         check("R1 drdy power-up phase", o_drdy(i), i);
      end
      for (int k = 0; k < HN; k++) begin
         hist_d[k] = 0;
         hist_r[k] = 0;
      end
      n = 0;
      m_rso = 0;
      p_rso = 0;
      rel_seen = 1'b0;
      rel_edge = 0;
      for (int i = 0; i < 2; i++) begin
         m_drdy[i] = i;
         m_pri[i] = 0;
         m_aux[i] = 0;
         p_drdy[i] = i;
         p_pri[i] = 0;
         p_aux[i] = 0;
         swl[i] = 0;
      end
      rst_n = 1'b1;
   endtask

   // One input clock: drive, advance the model at the edge, compare at the falling edge.
   task automatic cyc(input logic [7:0] d, input logic r);
      int  ce;
      bit  rel;
      bit  rise;
      smp = d;
      rsync = r;
      @(posedge clk);
      ce = n;
      hist_d[ce] = int'(d);
      hist_r[ce] = int'(r);
      rel = (getr(ce - R - 1) == 1) && (getr(ce - R) == 0);
      if (rel) begin
         rel_seen = 1'b1;
         rel_edge = ce;
      end
      for (int i = 0; i < 2; i++) begin
         rise = (m_drdy[i] == 0) && !rel;
         if (rise) begin
            m_pri[i] = getd(ce - P);
            m_aux[i] = getd(ce - P - 1);
         end
         m_drdy[i] = rel ? 0 : 1 - m_drdy[i];
      end
      m_rso = getr(ce - R);
      n++;
      @(negedge clk);
      for (int i = 0; i < 2; i++) begin
         check("R4 primary sample", o_pri(i), m_pri[i]);
         check("R4 auxiliary older sample", o_aux(i), m_aux[i]);
         check("R2 R7 drdy level", o_drdy(i), m_drdy[i]);
         check("R5 resync out", o_rso(i), m_rso);
         if (!(p_drdy[i] == 0 && o_drdy(i) == 1)) begin
            check("R3 primary held", o_pri(i), p_pri[i]);
            check("R3 auxiliary held", o_aux(i), p_aux[i]);
         end
         if (p_rso == 1 && o_rso(i) == 1)
            check("R6 drdy runs in resync", o_drdy(i), 1 - p_drdy[i]);
         if (o_drdy(i) == p_drdy[i]) swl[i]++;
      end
      if (rel_seen && ce >= rel_edge + 1) begin
         check("R8 primary phase-independent", o_pri(0), o_pri(1));
         check("R8 auxiliary phase-independent", o_aux(0), o_aux(1));
         check("R8 drdy phase-independent", o_drdy(0), o_drdy(1));
      end
      for (int i = 0; i < 2; i++) begin
         p_drdy[i] = o_drdy(i);
         p_pri[i] = o_pri(i);
         p_aux[i] = o_aux(i);
      end
      p_rso = o_rso(0);
   endtask

   initial begin
      // Vector table: one resync pulse per run over a chosen data pattern.
      for (int v = 0; v < NV; v++) begin
         sys_reset();
         for (int k = 0; k < 70; k++) begin
            cyc(pat(VEC[v][2], k), (k >= VEC[v][0]) && (k < VEC[v][0] + VEC[v][1]));
         end
         check("R7 exactly one instance swallows", swl[0] + swl[1], 1);
         check("R7 release seen", int'(rel_seen), 1);
      end

      // Directed: a second pulse once aligned must not interrupt either stream (R7).
      sys_reset();
      for (int k = 0; k < 80; k++) begin
         cyc(pat(0, k), ((k >= 12) && (k < 14)) || ((k >= 32) && (k < 34)));
         if (k == 22) begin
            swl[0] = 0;
            swl[1] = 0;
         end
      end
      check("R7 aligned resync u0 no swallow", swl[0], 0);
      check("R7 aligned resync u1 no swallow", swl[1], 0);

      // Directed: single-cycle pulse reproduced with width one (R5).
      sys_reset();
      for (int k = 0; k < 12; k++) cyc(pat(2, k), k == 3);
      check("R5 one-cycle pulse gone", o_rso(0), 0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         nchk++;
         nfail++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
         $finish;
      end
   end

endmodule